// File: doc/BRIEF.md
# Single-Stage CIC Decimator with Strobed Output

This block is a decimating filter with no multipliers. It is built from one integrator, a comb made from a delay line, and a counter that marks the output phase. Samples are signed 16-bit fixed point with 14 fractional bits, so a sample's value is its integer code divided by 16384. The integrator adds each accepted sample into a running sum. The comb subtracts from that sum its own value from R accepted samples earlier. The difference is the sum of the last R inputs, which is a boxcar average scaled by R.

The input `valid_in` acts as a filter enable: the sum, the delay line and the phase counter advance only on cycles where it is high. The counter raises `valid_out` on the last enabled cycle of each group of R. On that cycle `data_out` carries the comb result. On every other cycle `data_out` reads zero; it does not hold the last decimated value. All arithmetic wraps in two's complement without saturation, so an overflow in the integrator cancels out in the comb.

Top module: `cic_decim`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the sum, every delay stage and the phase counter. The first `valid_out` therefore appears on the R-th enabled cycle after reset is released (the 5th for R = 5), and `valid_out` is low before it.
- R2: `valid_out` is high on exactly one enabled cycle in each group of R enabled cycles, and never on two consecutive cycles.
- R3: Whenever `valid_out` is low, `data_out` is 16'h0000.
- R4: On each enabled cycle the sum grows by `data_in` modulo 2^16. As a result, the first strobe after reset outputs the sum of the first R−1 enabled inputs (0x8000 for a constant input of 0x2000).
- R5: On a strobe, `data_out` equals the current sum minus the sum from R enabled cycles earlier. In steady state this is R times a constant input, modulo 2^16 (0xA000 for an input of 0x2000).
- R6: While `valid_in` is low, `valid_out` is low and the sum, the delay stages and the counter hold their values, whatever `data_in` carries.
- R7: Wrap-around is not saturated. A constant 0x7FFF settles to (5 × 0x7FFF) mod 2^16 = 0x7FFB.
- R8: Inputs are signed. A constant 0xE000 (−0.5) settles to (5 × −0x2000) mod 2^16 = 0x6000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 16 | Signed input sample, 14 fractional bits |
| valid_in | input | 1 | Filter enable; advances the filter state |
| valid_out | output | 1 | One-cycle strobe per R enabled cycles |
| data_out | output | 16 | Comb result on a strobe, zero otherwise |

## Verification
A constant 0x2000 shows the fill-up: the first strobe, taken before the delay line is full, reads 0x8000, and later strobes read 0xA000. This separates a correct delay depth from a depth that is off by one. Full-scale positive and negative constants separate wrap-around from saturation and signed from unsigned handling. An irregular `valid_in` pattern, with `data_in` changing while the filter is stalled, shows whether stalled cycles are ignored. If they were not, both the strobe position and the sum at the strobe would move.

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int W = 16,
  parameter int R = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_in,
  input  logic         valid_in,
  output logic         valid_out,
  output logic [W-1:0] data_out
);
  localparam int CW = (R > 1) ? $clog2(R) : 1;
  localparam logic [CW-1:0] LAST = CW'(R - 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  tap [R];
  logic [CW-1:0] phase;
  logic [W-1:0]  diff;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (valid_in) acc <= acc + data_in;
  end

  for (genvar i = 0; i < R; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) tap[i] <= '0;
      else if (valid_in) tap[i] <= (i == 0) ? acc : tap[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (valid_in) phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign diff      = acc - tap[R-1];
  assign valid_out = valid_in && (phase == LAST);
  assign data_out  = valid_out ? diff : '0;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);                                                    // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_out |=> !valid_out);                                         // R2
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> acc == W'($past(acc) + $past(data_in)));              // R4
  AST_LINE_FEED: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> tap[0] == $past(acc));                                // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(acc) && $stable(phase) && $stable(tap[R-1])); // R6
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid_in |-> !valid_out && data_out == '0);                       // R6
endmodule

// File: tb/cic_decim_test.sv
module cic_decim_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int R = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] data_in = '0;
  logic valid_in = 1'b0;
  logic valid_out;
  logic [W-1:0] data_out;

  int compared = 0;
  int mismatched = 0;

  logic [W-1:0] m_sum;
  logic [W-1:0] m_hist [R];
  int m_cnt;
  logic [W-1:0] last_data;
  int enabled_seen;
  int first_strobe;
  logic [W-1:0] first_data;

  cic_decim #(.W(W), .R(R)) uut (
    .clk(clk), .rst(rst), .data_in(data_in), .valid_in(valid_in),
    .valid_out(valid_out), .data_out(data_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; valid_in = 1'b0; data_in = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_sum = '0; m_cnt = 0; enabled_seen = 0; first_strobe = -1;
    for (int i = 0; i < R; i++) m_hist[i] = '0;
  endtask

  task automatic step(input logic [W-1:0] x, input logic v);
    logic ev;
    logic [W-1:0] ed;
    @(negedge clk);
    data_in = x; valid_in = v;
    #1;
    ev = v && (m_cnt == R-1);
    ed = ev ? W'(m_sum - m_hist[R-1]) : '0;
    check("R2 valid_out", W'(valid_out), W'(ev));
    check(ev ? "R5 data_out on strobe" : "R3 data_out between strobes", data_out, ed);
    if (valid_out) begin
      last_data = data_out;
      if (first_strobe < 0) begin first_strobe = enabled_seen; first_data = data_out; end
    end
    @(posedge clk);
    if (v) begin
      for (int i = R-1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = m_sum;
      m_sum = m_sum + x;
      m_cnt = (m_cnt == R-1) ? 0 : m_cnt + 1;
      enabled_seen++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk); #1;
    check("R1 valid_out after reset", W'(valid_out), '0);
    check("R1 data_out after reset", data_out, '0);
  endtask

  task automatic t_constant();
    do_reset();
    for (int k = 0; k < 4*R; k++) step(16'h2000, 1'b1);
    check("R1 first strobe enabled index", W'(first_strobe), W'(R-1));
    check("R4 first strobe partial sum", first_data, 16'h8000);
    check("R5 steady state", last_data, 16'hA000);
  endtask

  task automatic t_stall();
    logic [W-1:0] s;
    do_reset();
    step(16'h0100, 1'b1);
    step(16'h0200, 1'b1);
    for (int k = 0; k < 4; k++) step(16'h7777, 1'b0);
    step(16'h0040, 1'b1);
    for (int k = 0; k < 3; k++) step(16'hF000, 1'b0);
    step(16'h0008, 1'b1);
    s = 16'h0100 + 16'h0200 + 16'h0040 + 16'h0008;
    @(negedge clk);
    data_in = 16'h0001; valid_in = 1'b1;
    #1;
    check("R6 strobe on 5th enabled cycle", W'(valid_out), 16'h0001);
    check("R6 sum ignores stalled inputs", data_out, s);
    @(posedge clk);
    @(negedge clk);
    valid_in = 1'b0;
    do_reset();
    for (int k = 0; k < 25; k++) step(W'(k * 16'h0123), (k % 3) != 1);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int k = 0; k < 3*R; k++) step(16'h7FFF, 1'b1);
    check("R7 wrap not saturated", last_data, 16'h7FFB);
  endtask

  task automatic t_negative();
    do_reset();
    for (int k = 0; k < 3*R; k++) step(16'hE000, 1'b1);
    check("R8 signed negative input", last_data, 16'h6000);
  endtask

  initial begin
    t_reset();
    t_constant();
    t_stall();
    t_wrap();
    t_negative();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule